// File: doc/BRIEF.md
# Injected-Event Fault Escalation Controller

This block follows the delivery of a single event that is injected while entering a guest context. A start strobe carries the event's interruption type and vector. While the event is being delivered, the surrounding logic reports each nested exception it runs into. Each report carries the exception vector and a flag that says whether this pairing escalates to a double fault. For every report the controller decides one of three outcomes. It can push an error code, and it chooses the EXT bit for that code. It can produce a double-fault error code. Or it can ask the host to take an exit, with a reason of nested exception or triple fault. A 32-bit exception bitmap selects which nested vectors trap to the host.

The controller is a six-state machine:

- **IDLE**: waits for a start strobe. An accepted start moves to **DELIVER**, or to **DOUBLE_FAULT** when the injected event is itself a double fault.
- **DELIVER**: no nested exception has been seen yet. A report moves to one of three states:
  - **EXIT** when the vector traps.
  - **DOUBLE_FAULT** when the report escalates.
  - **NESTED** otherwise.
- **NESTED**: at least one non-escalating nested exception has been seen. It stays in **NESTED** on further plain reports. It moves to **EXIT** on a trap and to **DOUBLE_FAULT** on escalation.
- **DOUBLE_FAULT**: the double-fault handler is being invoked. Any report here leads to **EXIT**, with reason exception if the vector traps and triple fault if it does not.
- **DONE** is reached from DELIVER, NESTED or DOUBLE_FAULT when delivery completes. A nested report outranks completion when both arrive in the same cycle.
- **EXIT** and **DONE** each last one cycle and then return to **IDLE**.

Every output is registered. Each appears in the cycle after the clock edge that sampled its cause.

Top module: `inj_fault_ctrl`

## Requirements
- R1: The injected event never raises an exit request. From an accepted start until the first nested report, `exit_o` stays 0, even when the bitmap has every bit set, including the injected vector's bit.
- R2: For injected types 0 (external interrupt), 2 (NMI), 3 (hardware exception) and 5 (privileged software exception), the first non-trapped, non-escalating nested exception pulses `err_valid_o` with `err_ext_o`=1. The undefined codes 1 and 7 behave as type 3.
- R3: For injected types 4 (software interrupt) and 6 (software exception), that first nested error code has `err_ext_o`=0.
- R4: Every later non-trapped, non-escalating nested exception in the same delivery pulses `err_valid_o` with `err_ext_o`=1, whatever the injected type.
- R5: A non-trapped nested report with the escalate flag set pulses `df_valid_o`, with `df_code_o`=16'h0000 and no `err_valid_o` or `exit_o` in that cycle.
- R6: A nested vector below 32 whose bitmap bit is set pulses `exit_o` with `exit_reason_o`=1 (nested exception). A vector of 32 or above, or one whose bit is clear, never traps, and delivery continues.
- R7: In DOUBLE_FAULT, a further nested report gives an exit. The reason is 2 (triple fault) when its bitmap bit is clear and 1 when it is set.
- R8: An injected hardware-class event with vector 8 starts in DOUBLE_FAULT. Its first untrapped nested report gives a triple-fault exit, with reason 2.
- R9: When `lbr_en_i` is 1 at an accepted start, `brec_o` pulses for one cycle in the next cycle, for any vector, including debug vector 1.
- R10: When `deliver_done_i` arrives in a delivering state, `done_o` pulses for one cycle. `done_o` and `exit_o` are never high together, and neither stays high for two cycles. A nested report in the same cycle as `deliver_done_i` takes precedence.
- R11: A start strobe outside IDLE is ignored. It changes neither the EXT rule of the running delivery nor `brec_o`.
- R12: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for an injected event |
| start_type_i | input | 3 | Interruption type of the injected event |
| start_vec_i | input | 8 | Vector of the injected event |
| lbr_en_i | input | 1 | Branch-record enable sampled at start |
| nest_valid_i | input | 1 | A nested exception is reported this cycle |
| nest_vec_i | input | 8 | Vector of the nested exception |
| nest_df_i | input | 1 | This nested pairing escalates to a double fault |
| bitmap_i | input | 32 | Exception bitmap, one bit per vector 0..31 |
| deliver_done_i | input | 1 | Event delivery completed |
| err_valid_o | output | 1 | An error code is pushed for a nested exception |
| err_ext_o | output | 1 | EXT bit of that error code |
| df_valid_o | output | 1 | A double fault is produced |
| df_code_o | output | 16 | Double-fault error code |
| exit_o | output | 1 | Exit request pulse |
| exit_reason_o | output | 2 | Exit reason: 1 nested exception, 2 triple fault, 0 when no exit |
| brec_o | output | 1 | Branch-record log strobe |
| done_o | output | 1 | Delivery-complete pulse |

## Verification
The hardest situation to reach from the ports is a triple fault raised while the double-fault handler is being invoked. Getting there takes an accepted start, then a nested report that escalates, then a second untrapped report. The bitmap must be clear for the first vector and chosen for the second, in consecutive cycles. Directed sequences drive exactly that chain, and then repeat it with the second vector trapped so that both exit reasons are covered. A second directed case pushes a conflicting start strobe into the middle of a delivery, and then checks the EXT bit and the branch-record strobe that follow.

// File: rtl/evt_inj_pkg.sv
package evt_inj_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DELIVER,
        S_NESTED,
        S_DFAULT,
        S_EXIT,
        S_DONE
    } state_e;

    typedef enum logic [1:0] {
        RSN_NONE   = 2'd0,
        RSN_EXC    = 2'd1,
        RSN_TRIPLE = 2'd2
    } reason_e;

    localparam logic [2:0] TYP_EXT_INT  = 3'd0;
    localparam logic [2:0] TYP_NMI      = 3'd2;
    localparam logic [2:0] TYP_SW_INT   = 3'd4;
    localparam logic [2:0] TYP_PRIV_SW  = 3'd5;
    localparam logic [2:0] TYP_SW_EXC   = 3'd6;

endpackage

// File: rtl/inj_type_decode.sv
module inj_type_decode
    import evt_inj_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int DF_VEC = 8
) (
    input  logic [2:0]       typ_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic             ext_first_o,
    output logic             is_df_o
);

    logic hw_class;

    always_comb begin
        ext_first_o = 1'b1;
        hw_class    = 1'b1;
        case (typ_i)
            TYP_EXT_INT, TYP_NMI, TYP_PRIV_SW: hw_class = 1'b0;
            TYP_SW_INT, TYP_SW_EXC: begin
                hw_class    = 1'b0;
                ext_first_o = 1'b0;
            end
            default: hw_class = 1'b1;
        endcase
        is_df_o = hw_class && (vec_i == VEC_W'(DF_VEC));
    end

endmodule

// File: rtl/inj_trap_lookup.sv
module inj_trap_lookup #(
    parameter int VEC_W = 8,
    parameter int MAP_W = 32
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic [MAP_W-1:0] map_i,
    output logic             hit_o
);

    localparam int IDX_W = $clog2(MAP_W);

    generate
        if (VEC_W > IDX_W) begin : g_wide
            assign hit_o = ~|vec_i[VEC_W-1:IDX_W] && map_i[vec_i[IDX_W-1:0]];
        end else begin : g_narrow
            assign hit_o = map_i[vec_i];
        end
    endgenerate

endmodule

// File: rtl/inj_fsm.sv
module inj_fsm
    import evt_inj_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       ext_first_i,
    input  logic       inj_is_df_i,
    input  logic       lbr_en_i,
    input  logic       nest_valid_i,
    input  logic       nest_df_i,
    input  logic       trap_hit_i,
    input  logic       deliver_done_i,
    output logic       err_valid_o,
    output logic       err_ext_o,
    output logic       df_valid_o,
    output logic       exit_o,
    output logic [1:0] exit_reason_o,
    output logic       brec_o,
    output logic       done_o,
    output logic       idle_o,
    output logic       delivering_o
);

    state_e  st, st_nxt;
    logic    ext_first_q;
    logic    a_err, a_ext, a_df, a_done;
    reason_e a_rsn;
    logic    accept;

    assign accept       = (st == S_IDLE) && start_i;
    assign idle_o       = (st == S_IDLE);
    assign delivering_o = (st == S_DELIVER) || (st == S_NESTED) || (st == S_DFAULT);

    always_comb begin
        st_nxt = st;
        a_err  = 1'b0;
        a_ext  = 1'b0;
        a_df   = 1'b0;
        a_done = 1'b0;
        a_rsn  = RSN_NONE;
        unique case (st)
            S_IDLE: begin
                if (start_i) st_nxt = inj_is_df_i ? S_DFAULT : S_DELIVER;
            end
            S_DELIVER, S_NESTED: begin
                if (nest_valid_i) begin
                    if (trap_hit_i) begin
                        st_nxt = S_EXIT;
                        a_rsn  = RSN_EXC;
                    end else if (nest_df_i) begin
                        st_nxt = S_DFAULT;
                        a_df   = 1'b1;
                    end else begin
                        st_nxt = S_NESTED;
                        a_err  = 1'b1;
                        a_ext  = (st == S_DELIVER) ? ext_first_q : 1'b1;
                    end
                end else if (deliver_done_i) begin
                    st_nxt = S_DONE;
                    a_done = 1'b1;
                end
            end
            S_DFAULT: begin
                if (nest_valid_i) begin
                    st_nxt = S_EXIT;
                    a_rsn  = trap_hit_i ? RSN_EXC : RSN_TRIPLE;
                end else if (deliver_done_i) begin
                    st_nxt = S_DONE;
                    a_done = 1'b1;
                end
            end
            S_EXIT:  st_nxt = S_IDLE;
            S_DONE:  st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            ext_first_q <= 1'b0;
        end else begin
            st <= st_nxt;
            if (accept) ext_first_q <= ext_first_i;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid_o   <= 1'b0;
            err_ext_o     <= 1'b0;
            df_valid_o    <= 1'b0;
            exit_o        <= 1'b0;
            exit_reason_o <= 2'd0;
            brec_o        <= 1'b0;
            done_o        <= 1'b0;
        end else begin
            err_valid_o   <= a_err;
            err_ext_o     <= a_err && a_ext;
            df_valid_o    <= a_df;
            exit_o        <= (a_rsn != RSN_NONE);
            exit_reason_o <= a_rsn;
            brec_o        <= accept && lbr_en_i;
            done_o        <= a_done;
        end
    end

endmodule

// File: rtl/inj_fault_ctrl.sv
module inj_fault_ctrl
    import evt_inj_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int MAP_W  = 32,
    parameter int EC_W   = 16,
    parameter int DF_VEC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       start_type_i,
    input  logic [VEC_W-1:0] start_vec_i,
    input  logic             lbr_en_i,
    input  logic             nest_valid_i,
    input  logic [VEC_W-1:0] nest_vec_i,
    input  logic             nest_df_i,
    input  logic [MAP_W-1:0] bitmap_i,
    input  logic             deliver_done_i,
    output logic             err_valid_o,
    output logic             err_ext_o,
    output logic             df_valid_o,
    output logic [EC_W-1:0]  df_code_o,
    output logic             exit_o,
    output logic [1:0]       exit_reason_o,
    output logic             brec_o,
    output logic             done_o
);

    logic ext_first, inj_is_df, trap_hit;
    logic fsm_idle, fsm_delivering;

    inj_type_decode #(.VEC_W(VEC_W), .DF_VEC(DF_VEC)) u_dec (
        .typ_i       (start_type_i),
        .vec_i       (start_vec_i),
        .ext_first_o (ext_first),
        .is_df_o     (inj_is_df)
    );

    inj_trap_lookup #(.VEC_W(VEC_W), .MAP_W(MAP_W)) u_trap (
        .vec_i (nest_vec_i),
        .map_i (bitmap_i),
        .hit_o (trap_hit)
    );

    inj_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .ext_first_i    (ext_first),
        .inj_is_df_i    (inj_is_df),
        .lbr_en_i       (lbr_en_i),
        .nest_valid_i   (nest_valid_i),
        .nest_df_i      (nest_df_i),
        .trap_hit_i     (trap_hit),
        .deliver_done_i (deliver_done_i),
        .err_valid_o    (err_valid_o),
        .err_ext_o      (err_ext_o),
        .df_valid_o     (df_valid_o),
        .exit_o         (exit_o),
        .exit_reason_o  (exit_reason_o),
        .brec_o         (brec_o),
        .done_o         (done_o),
        .idle_o         (fsm_idle),
        .delivering_o   (fsm_delivering)
    );

    // a double fault always pushes an all-zero code with EXT clear
    assign df_code_o = '0;

endmodule

// File: rtl/inj_fault_ctrl_chk.sv
module inj_fault_ctrl_chk #(
    parameter int VEC_W = 8,
    parameter int MAP_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             lbr_en_i,
    input logic             nest_valid_i,
    input logic [VEC_W-1:0] nest_vec_i,
    input logic [MAP_W-1:0] bitmap_i,
    input logic             err_valid_o,
    input logic             df_valid_o,
    input logic             exit_o,
    input logic [1:0]       exit_reason_o,
    input logic             brec_o,
    input logic             done_o,
    input logic             fsm_idle,
    input logic             fsm_delivering
);

    localparam int IDX_W = $clog2(MAP_W);

    logic trapped;
    assign trapped = (32'(nest_vec_i) < MAP_W) && bitmap_i[nest_vec_i[IDX_W-1:0]];

    // R1
    inject_no_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle && start_i |=> !exit_o);

    // R6
    trap_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_delivering && nest_valid_i && trapped |=> exit_o && exit_reason_o == 2'd1);

    // R6
    untrapped_no_exc_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_delivering && nest_valid_i && !trapped |=> !(exit_o && exit_reason_o == 2'd1));

    // R10
    exit_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exit_o && done_o));

    // R10
    exit_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_o |=> !exit_o);

    // R10
    done_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    df_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        df_valid_o |-> !err_valid_o && !exit_o);

    // R9
    brec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle && start_i && lbr_en_i |=> brec_o);

    // R11
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fsm_idle && start_i |=> !brec_o);

endmodule

bind inj_fault_ctrl inj_fault_ctrl_chk #(.VEC_W(VEC_W), .MAP_W(MAP_W)) u_chk (.*);

// File: tb/sim_inj_fault_ctrl.sv
`timescale 1ns/1ps
module sim_inj_fault_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, lbr_en_i, nest_valid_i, nest_df_i, deliver_done_i;
    logic [2:0]  start_type_i;
    logic [7:0]  start_vec_i, nest_vec_i;
    logic [31:0] bitmap_i;
    logic        err_valid_o, err_ext_o, df_valid_o, exit_o, brec_o, done_o;
    logic [15:0] df_code_o;
    logic [1:0]  exit_reason_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    inj_fault_ctrl u0 (.*);

    typedef struct packed {
        logic [2:0] typ;
        logic [7:0] ivec;
        logic [7:0] nvec;
        logic       ndf;
        logic       trap;
        logic       e_err;
        logic       e_ext;
        logic       e_df;
        logic [1:0] e_rsn;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t ROWS [NROWS] = '{
        '{3'd0, 8'h20, 8'd13, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        '{3'd2, 8'h02, 8'd14, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        '{3'd3, 8'h01, 8'd13, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        '{3'd5, 8'h01, 8'd11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        '{3'd4, 8'h80, 8'd13, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        '{3'd6, 8'h03, 8'd12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        '{3'd7, 8'h05, 8'd13, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        '{3'd0, 8'h21, 8'd14, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
        '{3'd4, 8'h80, 8'd11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
        '{3'd3, 8'h08, 8'd13, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2},
        '{3'd3, 8'h08, 8'd13, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
        '{3'd2, 8'h02, 8'd40, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start_evt(input logic [2:0] t, input logic [7:0] v, input logic lbr,
                             input logic [31:0] map);
        start_i = 1'b1; start_type_i = t; start_vec_i = v; lbr_en_i = lbr; bitmap_i = map;
        @(negedge clk);
        start_i = 1'b0; lbr_en_i = 1'b0;
    endtask

    task automatic nest(input logic [7:0] v, input logic df, input logic [31:0] map);
        nest_valid_i = 1'b1; nest_vec_i = v; nest_df_i = df; bitmap_i = map;
        @(negedge clk);
        nest_valid_i = 1'b0; nest_df_i = 1'b0;
    endtask

    task automatic finish_done(input string req);
        deliver_done_i = 1'b1;
        @(negedge clk);
        deliver_done_i = 1'b0;
        chk(req, "done pulse", done_o, 1);
        chk(req, "exit with done", exit_o, 0);
        @(negedge clk);
        chk(req, "done one cycle", done_o, 0);
    endtask

    task automatic run_row(input row_t r, input int idx);
        string tag;
        logic  lbr;
        lbr = idx[0];
        tag = (r.e_rsn == 2'd2) ? "R8" : (r.e_rsn == 2'd1) ? "R6" :
              r.e_df ? "R5" : r.e_ext ? "R2" : "R3";
        start_evt(r.typ, r.ivec, lbr, 32'hFFFF_FFFF);
        chk("R9", "brec after start", brec_o, int'(lbr));
        chk("R1", "no exit on injection", exit_o, 0);
        nest(r.nvec, r.ndf, r.trap ? 32'hFFFF_FFFF : 32'h0);
        chk(tag, "err_valid", err_valid_o, int'(r.e_err));
        chk(tag, "err_ext", err_ext_o, int'(r.e_ext));
        chk(tag, "df_valid", df_valid_o, int'(r.e_df));
        if (r.e_df) chk("R5", "df_code", int'(df_code_o), 0);
        chk(tag, "exit", exit_o, int'(r.e_rsn != 2'd0));
        chk(tag, "exit_reason", int'(exit_reason_o), int'(r.e_rsn));
        if (r.e_rsn != 2'd0) begin
            @(negedge clk);
            chk("R10", "exit one cycle", exit_o, 0);
        end else begin
            finish_done("R10");
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; start_type_i = '0; start_vec_i = '0; lbr_en_i = 1'b0;
        nest_valid_i = 1'b0; nest_vec_i = '0; nest_df_i = 1'b0; bitmap_i = '0;
        deliver_done_i = 1'b0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "outputs in reset",
            int'({err_valid_o, err_ext_o, df_valid_o, exit_o, brec_o, done_o, exit_reason_o}), 0);
        chk("R12", "df_code in reset", int'(df_code_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "outputs after reset",
            int'({err_valid_o, err_ext_o, df_valid_o, exit_o, brec_o, done_o, exit_reason_o}), 0);

        for (int i = 0; i < NROWS; i++) run_row(ROWS[i], i);

        // R4: deeper nesting under a software interrupt
        start_evt(3'd4, 8'h80, 1'b0, 32'h0);
        nest(8'd13, 1'b0, 32'h0);
        chk("R3", "first nested ext", err_ext_o, 0);
        nest(8'd14, 1'b0, 32'h0);
        chk("R4", "second nested err", err_valid_o, 1);
        chk("R4", "second nested ext", err_ext_o, 1);
        nest(8'd6, 1'b0, 32'h0);
        chk("R4", "third nested ext", err_ext_o, 1);
        finish_done("R10");
        @(negedge clk);

        // R7: exception while invoking double-fault handler, untrapped
        start_evt(3'd0, 8'h30, 1'b0, 32'h0);
        nest(8'd13, 1'b1, 32'h0);
        chk("R5", "df after escalation", df_valid_o, 1);
        chk("R5", "df code", int'(df_code_o), 0);
        nest(8'd14, 1'b0, 32'h0);
        chk("R7", "triple exit", exit_o, 1);
        chk("R7", "triple reason", int'(exit_reason_o), 2);
        @(negedge clk);
        @(negedge clk);

        // R7: same chain, second vector trapped
        start_evt(3'd0, 8'h30, 1'b0, 32'h0);
        nest(8'd13, 1'b1, 32'h0);
        nest(8'd14, 1'b0, 32'h0000_4000);
        chk("R7", "trapped exit", exit_o, 1);
        chk("R7", "trapped reason", int'(exit_reason_o), 1);
        @(negedge clk);
        @(negedge clk);

        // R11: start while busy is ignored
        start_evt(3'd0, 8'h22, 1'b0, 32'h0);
        start_evt(3'd4, 8'h80, 1'b1, 32'h0);
        chk("R11", "brec on ignored start", brec_o, 0);
        nest(8'd13, 1'b0, 32'h0);
        chk("R11", "ext keeps first type", err_ext_o, 1);
        finish_done("R10");
        @(negedge clk);

        // R1: injected NMI with every bitmap bit set, held without nesting
        start_evt(3'd2, 8'h02, 1'b1, 32'hFFFF_FFFF);
        chk("R9", "brec for NMI", brec_o, 1);
        @(negedge clk);
        chk("R9", "brec one cycle", brec_o, 0);
        for (int k = 0; k < 3; k++) begin
            chk("R1", "no exit while injecting", exit_o, 0);
            @(negedge clk);
        end
        finish_done("R10");
        @(negedge clk);

        // R10: nested report outranks completion in the same cycle
        start_evt(3'd6, 8'h03, 1'b0, 32'h0);
        deliver_done_i = 1'b1;
        nest(8'd13, 1'b0, 32'h0);
        deliver_done_i = 1'b0;
        chk("R10", "nest wins err", err_valid_o, 1);
        chk("R10", "no done on tie", done_o, 0);
        finish_done("R10");
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule